// File: doc/BRIEF.md
# Serial Configuration Word Sequencer

This block sits on the controller side of a write-only, three-wire programming link to an external clock generator. A 160-bit configuration word is handed over through a valid/ready handshake. The block then puts the bits on a serial data line, most significant bit first, with a rising serial clock edge for each bit. After the last bit it waits, sends one strobe pulse to latch the word, and raises a one-cycle done flag.

Every interval on the link is a parameter in picoseconds. Each one is turned into a count of system clock cycles, rounded up. These intervals are data setup before a clock edge, data hold after it, the shortest serial clock period, the gap before the strobe and the strobe width. The strobe stays low for the whole shift phase, so the receiver's transparent latch never sees a partly shifted word. While a word is in progress, ready stays low and any word offered on the input is dropped.

Top module: `serprog_seq`

## Requirements
- R1: During and right after reset, cfg_ready is 1 and ser_clk, ser_strobe and done are 0.
- R2: The cycle after a word is accepted (cfg_valid and cfg_ready both 1 at a rising edge), cfg_ready is 0. It stays 0 until the done pulse has been given.
- R3: Each accepted word produces exactly WORD_W rising edges of ser_clk. ser_data at the k-th rising edge carries word bit WORD_W-k, so bit WORD_W-1 goes first.
- R4: ser_data is stable for at least ceil(SETUP_PS/CLK_PERIOD_PS) cycles before each rising edge of ser_clk.
- R5: ser_data does not change until at least ceil(HOLD_PS/CLK_PERIOD_PS) cycles after a rising edge of ser_clk, and never while ser_clk is high.
- R6: Consecutive rising edges of ser_clk within a word are at least ceil(SCLK_MIN_PER_PS/CLK_PERIOD_PS) cycles apart.
- R7: ser_strobe is 0 while any bit of the word is still to be shifted. It rises no sooner than ceil(WAIT_PS/CLK_PERIOD_PS) cycles after the last falling edge of ser_clk.
- R8: Each word gives exactly one ser_strobe pulse, and it is high for at least ceil(STROBE_PS/CLK_PERIOD_PS) cycles.
- R9: done is high for exactly one cycle, the first cycle in which ser_strobe is low again. cfg_ready returns to 1 in the next cycle.
- R10: A word offered while cfg_ready is 0 is ignored: it starts no transfer and changes nothing that is shifted out.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_valid | input | 1 | Configuration word offered |
| cfg_ready | output | 1 | Sequencer idle and able to take a word |
| cfg_word | input | WORD_W | Configuration word, bit WORD_W-1 is sent first |
| ser_clk | output | 1 | Serial shift clock to the device |
| ser_data | output | 1 | Serial data to the device |
| ser_strobe | output | 1 | Latch strobe to the device |
| done | output | 1 | One-cycle pulse when the word has been latched |

## Verification
The bench builds the block with its defaults: a 160-bit word and a 4 ns system clock. From these, setup, hold and gap round up to 3 cycles, the strobe to 10 cycles and the serial clock period to 9 cycles. Because the half period (5 cycles) is longer than setup and hold, the setup and hold margins at the edges can be seen as distinct from the 3-cycle floors. Word patterns with alternating, all-one, single-end and mixed bits show whether each bit position is shifted in order, and not just whether the data line toggles. A word offered for many cycles during a transfer checks that a busy sequencer ignores it.

// File: rtl/serprog_pkg.sv
package serprog_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_SETUP,
    ST_HIGH,
    ST_LOW,
    ST_WAIT,
    ST_STROBE,
    ST_DONE
  } seq_state_t;

  // Convert a duration to whole clock cycles, rounding up, never below one.
  function automatic int unsigned ps_to_cycles(input int unsigned dur_ps,
                                               input int unsigned per_ps);
    int unsigned c;
    c = (dur_ps + per_ps - 1) / per_ps;
    if (c == 0) c = 1;
    return c;
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/serprog_timer.sv
module serprog_timer #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/serprog_shifter.sv
module serprog_shifter #(
  parameter int unsigned WORD_W = 160,
  localparam int unsigned IDX_W = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              capture,
  input  logic [WORD_W-1:0] word_in,
  input  logic              shift,
  output logic              ser_bit,
  output logic              last_bit
);

  logic [WORD_W-1:0] sreg_q;
  logic [IDX_W-1:0]  bidx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg_q <= '0;
      bidx_q <= '0;
    end else if (capture) begin
      sreg_q <= word_in;
      bidx_q <= IDX_W'(WORD_W - 1);
    end else if (shift) begin
      sreg_q <= {sreg_q[WORD_W-2:0], 1'b0};
      bidx_q <= bidx_q - 1'b1;
    end
  end

  assign ser_bit  = sreg_q[WORD_W-1];
  assign last_bit = (bidx_q == '0);

  // R3: the control never asks for a shift beyond the final bit
  assert_no_shift_past_end_R3: assert property (@(posedge clk) disable iff (rst)
    shift |-> !last_bit);

endmodule

// File: rtl/serprog_fsm.sv
module serprog_fsm
  import serprog_pkg::*;
#(
  parameter int unsigned CNT_W      = 4,
  parameter int unsigned SETUP_CYC  = 5,
  parameter int unsigned HIGH_CYC   = 5,
  parameter int unsigned WAIT_CYC   = 3,
  parameter int unsigned STROBE_CYC = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_valid,
  input  logic             last_bit,
  input  logic             tmr_expired,
  output logic             cfg_ready,
  output logic             ser_clk,
  output logic             ser_strobe,
  output logic             done,
  output logic             capture,
  output logic             shift,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val
);

  seq_state_t state_q, state_d;
  logic ready_q, sclk_q, strobe_q, done_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (cfg_valid && ready_q) state_d = ST_LOAD;
      ST_LOAD:   state_d = ST_SETUP;
      ST_SETUP:  if (tmr_expired) state_d = ST_HIGH;
      ST_HIGH:   if (tmr_expired) state_d = last_bit ? ST_WAIT : ST_LOW;
      ST_LOW:    state_d = ST_SETUP;
      ST_WAIT:   if (tmr_expired) state_d = ST_STROBE;
      ST_STROBE: if (tmr_expired) state_d = ST_DONE;
      ST_DONE:   state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    tmr_val = '0;
    unique case (state_d)
      ST_SETUP:  tmr_val = CNT_W'(SETUP_CYC - 1);
      ST_HIGH:   tmr_val = CNT_W'(HIGH_CYC - 1);
      ST_WAIT:   tmr_val = CNT_W'(WAIT_CYC - 1);
      ST_STROBE: tmr_val = CNT_W'(STROBE_CYC - 1);
      default:   tmr_val = '0;
    endcase
  end

  assign tmr_load = (state_d != state_q);
  assign capture  = (state_q == ST_IDLE) && cfg_valid && ready_q;
  assign shift    = (state_q == ST_LOW);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      ready_q  <= 1'b1;
      sclk_q   <= 1'b0;
      strobe_q <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      ready_q  <= (state_d == ST_IDLE);
      sclk_q   <= (state_d == ST_HIGH);
      strobe_q <= (state_d == ST_STROBE);
      done_q   <= (state_d == ST_DONE);
    end
  end

  assign cfg_ready  = ready_q;
  assign ser_clk    = sclk_q;
  assign ser_strobe = strobe_q;
  assign done       = done_q;

endmodule

// File: rtl/serprog_seq.sv
module serprog_seq
  import serprog_pkg::*;
#(
  parameter int unsigned WORD_W          = 160,
  parameter int unsigned CLK_PERIOD_PS   = 4000,
  parameter int unsigned SETUP_PS        = 10000,
  parameter int unsigned HOLD_PS         = 10000,
  parameter int unsigned WAIT_PS         = 10000,
  parameter int unsigned STROBE_PS       = 40000,
  parameter int unsigned SCLK_MIN_PER_PS = 33334
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_valid,
  output logic              cfg_ready,
  input  logic [WORD_W-1:0] cfg_word,
  output logic              ser_clk,
  output logic              ser_data,
  output logic              ser_strobe,
  output logic              done
);

  localparam int unsigned HALF_CYC   = ps_to_cycles((SCLK_MIN_PER_PS + 1) / 2, CLK_PERIOD_PS);
  localparam int unsigned SETUP_CYC  = umax(ps_to_cycles(SETUP_PS, CLK_PERIOD_PS), HALF_CYC);
  localparam int unsigned HIGH_CYC   = umax(ps_to_cycles(HOLD_PS, CLK_PERIOD_PS), HALF_CYC);
  localparam int unsigned WAIT_CYC   = ps_to_cycles(WAIT_PS, CLK_PERIOD_PS);
  localparam int unsigned STROBE_CYC = ps_to_cycles(STROBE_PS, CLK_PERIOD_PS);
  localparam int unsigned MAX_CYC    = umax(umax(SETUP_CYC, HIGH_CYC), umax(WAIT_CYC, STROBE_CYC));
  localparam int unsigned CNT_W      = $clog2(MAX_CYC + 1);

  logic             capture, shift, last_bit;
  logic             tmr_load, tmr_expired;
  logic [CNT_W-1:0] tmr_val;

  serprog_fsm #(
    .CNT_W      (CNT_W),
    .SETUP_CYC  (SETUP_CYC),
    .HIGH_CYC   (HIGH_CYC),
    .WAIT_CYC   (WAIT_CYC),
    .STROBE_CYC (STROBE_CYC)
  ) fsm_i (
    .clk         (clk),
    .rst         (rst),
    .cfg_valid   (cfg_valid),
    .last_bit    (last_bit),
    .tmr_expired (tmr_expired),
    .cfg_ready   (cfg_ready),
    .ser_clk     (ser_clk),
    .ser_strobe  (ser_strobe),
    .done        (done),
    .capture     (capture),
    .shift       (shift),
    .tmr_load    (tmr_load),
    .tmr_val     (tmr_val)
  );

  serprog_timer #(.CNT_W(CNT_W)) timer_i (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  serprog_shifter #(.WORD_W(WORD_W)) shifter_i (
    .clk      (clk),
    .rst      (rst),
    .capture  (capture),
    .word_in  (cfg_word),
    .shift    (shift),
    .ser_bit  (ser_data),
    .last_bit (last_bit)
  );

  assert_ready_drops_R2: assert property (@(posedge clk) disable iff (rst)
    (cfg_valid && cfg_ready) |=> !cfg_ready);

  assert_data_held_high_R5: assert property (@(posedge clk) disable iff (rst)
    (ser_clk && $past(ser_clk)) |-> $stable(ser_data));

  assert_strobe_apart_from_sclk_R7: assert property (@(posedge clk) disable iff (rst)
    ser_strobe |-> !ser_clk);

  assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_after_strobe_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(ser_strobe) |-> done);

endmodule

// File: tb/serprog_seq_tb_top.sv
module serprog_seq_tb_top;

  localparam int unsigned W      = 160;
  localparam int unsigned PER_PS = 4000;

  function automatic int ceil_cyc(input int unsigned ps);
    return (ps + PER_PS - 1) / PER_PS;
  endfunction

  localparam int SETUP_MIN = ceil_cyc(10000);
  localparam int HOLD_MIN  = ceil_cyc(10000);
  localparam int WAIT_MIN  = ceil_cyc(10000);
  localparam int STB_MIN   = ceil_cyc(40000);
  localparam int PER_MIN   = ceil_cyc(33334);

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cfg_valid = 1'b0;
  logic [W-1:0] cfg_word = '0;
  logic         cfg_ready, ser_clk, ser_data, ser_strobe, done;

  int checks = 0;
  int errors = 0;
  int words_latched = 0;
  logic [W-1:0] exp_q[$];

  always #2 clk = ~clk;

  serprog_seq dut_i (
    .clk        (clk),
    .rst        (rst),
    .cfg_valid  (cfg_valid),
    .cfg_ready  (cfg_ready),
    .cfg_word   (cfg_word),
    .ser_clk    (ser_clk),
    .ser_data   (ser_data),
    .ser_strobe (ser_strobe),
    .done       (done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic send(input logic [W-1:0] w);
    @(negedge clk);
    while (!cfg_ready) @(negedge clk);
    cfg_valid = 1'b1;
    cfg_word  = w;
    exp_q.push_back(w);
    @(negedge clk);
    cfg_valid = 1'b0;
  endtask

  // Monitor: samples 1 ns after each rising edge, away from both clock edges.
  logic         p_sclk = 0, p_data = 0, p_stb = 0, p_ready = 0, p_done = 0;
  logic         busy = 0;
  int           bits_seen = 0;
  int           since_dchg = 0, since_rise = 0, since_fall = 0, rise_gap = 0, stb_len = 0;
  logic [W-1:0] accum = '0;

  always @(posedge clk) begin
    #1;
    if (!rst) begin
      // R2 / R9 handshake
      if (cfg_valid && p_ready) begin
        chk(!cfg_ready, "R2", "ready low after accept", cfg_ready, 0);
        busy = 1;
      end else if (busy) begin
        if (!done && !p_done)
          chk(!cfg_ready, "R2", "ready low while busy", cfg_ready, 0);
      end
      if (p_done) begin
        chk(!done && cfg_ready, "R9", "done single, ready back", {done, cfg_ready}, 1);
        busy = 0;
      end
      // data change: hold check (R5)
      since_dchg++;
      since_rise++;
      since_fall++;
      rise_gap++;
      if (ser_data !== p_data) begin
        if (bits_seen > 0 && bits_seen < W)
          chk(since_rise >= HOLD_MIN && !ser_clk, "R5", "hold after rise", since_rise, HOLD_MIN);
        since_dchg = 0;
      end
      if (ser_clk && !p_sclk) begin
        chk(since_dchg >= SETUP_MIN, "R4", "setup before rise", since_dchg, SETUP_MIN);
        if (bits_seen > 0)
          chk(rise_gap >= PER_MIN, "R6", "rise to rise", rise_gap, PER_MIN);
        accum = {accum[W-2:0], ser_data};
        bits_seen++;
        since_rise = 0;
        rise_gap = 0;
      end
      if (!ser_clk && p_sclk) since_fall = 0;
      // strobe
      if (ser_strobe && bits_seen != W)
        chk(0, "R7", "strobe during shift", bits_seen, W);
      if (ser_strobe && !p_stb) begin
        chk(since_fall >= WAIT_MIN, "R7", "gap before strobe", since_fall, WAIT_MIN);
        chk(bits_seen == W, "R3", "bit count", bits_seen, W);
        if (exp_q.size() == 0) begin
          chk(0, "R10", "unexpected transfer", 1, 0);
        end else begin
          logic [W-1:0] e;
          e = exp_q.pop_front();
          chk(accum == e, "R3", "word msb first", accum[63:0], e[63:0]);
        end
        stb_len = 0;
      end
      if (ser_strobe) stb_len++;
      if (!ser_strobe && p_stb) begin
        chk(stb_len >= STB_MIN, "R8", "strobe width", stb_len, STB_MIN);
        chk(done === 1'b1, "R9", "done at strobe fall", done, 1);
        words_latched++;
        bits_seen = 0;
      end
    end
    p_sclk = ser_clk; p_data = ser_data; p_stb = ser_strobe;
    p_ready = cfg_ready; p_done = done;
  end

  task automatic wait_drained();
    while (exp_q.size() != 0 || busy) @(negedge clk);
    repeat (5) @(negedge clk);
  endtask

  initial begin
    fork
      begin
        repeat (100000) @(posedge clk);
        chk(0, "R1", "watchdog expired", 0, 1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    join_none
    repeat (4) @(negedge clk);
    chk(cfg_ready && !ser_clk && !ser_strobe && !done, "R1", "state in reset",
        {cfg_ready, ser_clk, ser_strobe, done}, 4'b1000);
    rst = 1'b0;
    @(negedge clk);
    chk(cfg_ready && !ser_clk && !ser_strobe && !done, "R1", "state after reset",
        {cfg_ready, ser_clk, ser_strobe, done}, 4'b1000);

    send({80{2'b10}});
    send({W{1'b1}});
    send({1'b1, {(W-2){1'b0}}, 1'b1});
    send({5{32'hC3A5_1E69}});
    wait_drained();

    // R10: a second word offered during a transfer is dropped
    send({5{32'h0F0F_F0F0}});
    repeat (20) @(negedge clk);
    cfg_valid = 1'b1;
    cfg_word  = {W{1'b1}};
    repeat (200) @(negedge clk);
    chk(!cfg_ready, "R10", "still busy while other word offered", cfg_ready, 0);
    cfg_valid = 1'b0;
    wait_drained();
    repeat (100) @(negedge clk);
    chk(words_latched == 5, "R10", "transfers after busy offer", words_latched, 5);
    chk(exp_q.size() == 0, "R3", "scoreboard empty", exp_q.size(), 0);
    chk(cfg_ready && !ser_clk && !ser_strobe, "R9", "idle at end",
        {cfg_ready, ser_clk, ser_strobe}, 3'b100);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule